// File: doc/BRIEF.md
# Ramp-Compare Converter Sequencer

This block is the digital half of a single-slope analog-to-digital converter. An external ramp rises from zero while an external comparator stays high, for as long as the ramp is below the analog input. The block counts clock cycles in a chain of decimal (BCD) digits while that comparator is high. When the comparator drops, the block captures the count into an output latch. It then restarts the ramp.

The comparator arrives asynchronously and is synchronized inside the block. A conversion ends on the high-to-low edge of the synchronized comparator. Three fixed steps follow that edge. First comes a capture cycle. Next comes a cycle that clears the counter and drives the ramp-reset output. A further settle cycle keeps the ramp in reset. Counting then resumes. The output digits keep the previous result for the whole of the next conversion. A one-cycle flag marks each update. A manual reset input aborts the conversion in progress and restarts the ramp.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While rst_ni is low, digits_o is 0, ovr_o is 0, done_o is 0 and ramp_rst_o is 1. ramp_rst_o is still 1 in the first cycle after reset is released.
- R2: The captured result equals the number of cycles in which the synchronized comparator was high during the counting phase. It is presented as BCD: digits_o[3:0] holds the units, [7:4] the tens and [11:8] the hundreds, each in the range 0 to 9.
- R3: The count saturates at 999. If one more count is requested at 999, ovr_o is captured as 1 together with the result. A count of exactly 999 gives ovr_o = 0.
- R4: cmp_i passes through a two-flop synchronizer. Take the first cycle in which cmp_i is low after being high during counting. done_o and the new digits appear 4 cycles after that cycle.
- R5: done_o is high for exactly one cycle per conversion. It is high in the same cycle in which digits_o and ovr_o take their new values.
- R6: ramp_rst_o is high in the done_o cycle and in the cycle after it. It is low in the cycle after that unless man_rst_i is high. The next conversion counts from zero.
- R7: digits_o and ovr_o do not change in any cycle in which done_o is low.
- R8: ramp_rst_o is high while man_rst_i is high and for one cycle after it falls. A manual reset during counting discards the partial count and gives no done_o pulse. The next result equals the input value alone.
- R9: A manual reset that lands in the capture cycle does not cancel the capture. done_o still pulses with the completed count, and ramp_rst_o still covers two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| man_rst_i | input | 1 | Manual restart of the ramp and counter, synchronous |
| cmp_i | input | 1 | Comparator, high while ramp is below input, asynchronous |
| ramp_rst_o | output | 1 | Holds the external ramp at zero |
| digits_o | output | 12 | Latched BCD result, hundreds in the top nibble |
| ovr_o | output | 1 | Latched overrange flag of the shown result |
| done_o | output | 1 | One-cycle pulse when the result updates |

## Verification
Two functions can fall in the same cycle: capture of the finished count, and a manual reset that clears the counter. The bench watches for the comparator's falling edge. It then counts three cycles to reach the capture cycle, and raises man_rst_i for exactly that cycle. The outcome counts as correct only if done_o still pulses in the next cycle with the completed value, and ramp_rst_o still spans two cycles. A later conversion must also restart from zero rather than continue the old count.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_COUNT  = 2'd0,
    ST_STROBE = 2'd1,
    ST_CLEAR  = 2'd2,
    ST_SETTLE = 2'd3
  } seq_state_e;

  localparam int unsigned DIGIT_W = 4;
endpackage

// File: rtl/adc_cmp_sync.sv
module adc_cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/adc_bcd_counter.sv
module adc_bcd_counter
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_DIGITS = 3,
  localparam int unsigned CNT_W = DIGIT_W * N_DIGITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovr_o
);
  logic [N_DIGITS-1:0] nine;
  logic                full;
  logic                ovr_q;

  assign full = &nine;

  for (genvar g = 0; g < N_DIGITS; g++) begin : g_dig
    logic [DIGIT_W-1:0] d_q;
    logic               step;

    assign nine[g] = (d_q == DIGIT_W'(9));

    if (g == 0) begin : g_lsd
      assign step = en_i & ~full;
    end else begin : g_up
      assign step = en_i & ~full & (&nine[g-1:0]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    d_q <= '0;
      else if (clr_i) d_q <= '0;
      else if (step)  d_q <= nine[g] ? '0 : d_q + DIGIT_W'(1);
    end

    assign count_o[DIGIT_W*g +: DIGIT_W] = d_q;
  end

  // saturate at all-nines, remember the lost count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ovr_q <= 1'b0;
    else if (clr_i)       ovr_q <= 1'b0;
    else if (en_i & full) ovr_q <= 1'b1;
  end

  assign ovr_o = ovr_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_s_i,
  input  logic man_rst_i,
  output logic count_en_o,
  output logic cnt_clr_o,
  output logic latch_en_o,
  output logic ramp_rst_o
);
  seq_state_e state_q, state_d;
  logic       armed_q;
  logic       in_count;
  logic       fall;

  assign in_count = (state_q == ST_COUNT);
  // edge only counts once the comparator was seen high inside this phase
  assign fall     = in_count & armed_q & ~cmp_s_i;

  always_comb begin
    state_d = state_q;
    if (man_rst_i) begin
      state_d = (state_q == ST_STROBE) ? ST_CLEAR : ST_SETTLE;
    end else begin
      unique case (state_q)
        ST_COUNT:  if (fall) state_d = ST_STROBE;
        ST_STROBE: state_d = ST_CLEAR;
        ST_CLEAR:  state_d = ST_SETTLE;
        ST_SETTLE: state_d = ST_COUNT;
        default:   state_d = ST_SETTLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SETTLE;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= in_count & cmp_s_i & ~man_rst_i;
    end
  end

  assign count_en_o = in_count & cmp_s_i & ~man_rst_i;
  assign latch_en_o = (state_q == ST_STROBE);
  assign cnt_clr_o  = man_rst_i | (state_q == ST_CLEAR) | (state_q == ST_SETTLE);
  assign ramp_rst_o = man_rst_i | (state_q == ST_CLEAR) | (state_q == ST_SETTLE);
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_DIGITS    = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = DIGIT_W * N_DIGITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             man_rst_i,
  input  logic             cmp_i,
  output logic             ramp_rst_o,
  output logic [CNT_W-1:0] digits_o,
  output logic             ovr_o,
  output logic             done_o
);
  logic             cmp_s;
  logic             count_en, cnt_clr, latch_en;
  logic [CNT_W-1:0] count;
  logic             cnt_ovr;
  logic [CNT_W-1:0] digits_q;
  logic             ovr_q, done_q;

  adc_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  adc_seq_fsm u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmp_s_i   (cmp_s),
    .man_rst_i (man_rst_i),
    .count_en_o(count_en),
    .cnt_clr_o (cnt_clr),
    .latch_en_o(latch_en),
    .ramp_rst_o(ramp_rst_o)
  );

  adc_bcd_counter #(.N_DIGITS(N_DIGITS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (count_en),
    .count_o(count),
    .ovr_o  (cnt_ovr)
  );

  // display latch: old result stays until the next strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      digits_q <= '0;
      ovr_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= latch_en;
      if (latch_en) begin
        digits_q <= count;
        ovr_q    <= cnt_ovr;
      end
    end
  end

  assign digits_o = digits_q;
  assign ovr_o    = ovr_q;
  assign done_o   = done_q;
endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
module ramp_adc_ctrl_chk #(
  parameter int unsigned N_DIGITS = 3,
  localparam int unsigned CNT_W = 4 * N_DIGITS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             man_rst_i,
  input logic             ramp_rst_o,
  input logic [CNT_W-1:0] digits_o,
  input logic             ovr_o,
  input logic             done_o
);
  localparam logic [CNT_W-1:0] ALL_NINE = {N_DIGITS{4'h9}};

  for (genvar g = 0; g < N_DIGITS; g++) begin : g_bcd
    p_digit_bcd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      digits_o[4*g +: 4] <= 4'd9);
  end

  p_ovr_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> (digits_o == ALL_NINE));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ramp_on_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ramp_rst_o);

  p_ramp_after_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ramp_rst_o);

  p_hold_digits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(digits_o) && $stable(ovr_o)));

  p_man_ramp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_rst_i |-> ramp_rst_o);

  p_man_settle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(man_rst_i) |-> ramp_rst_o);
endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.N_DIGITS(N_DIGITS)) chk_i (.*);

// File: tb/ramp_adc_ctrl_tb_top.sv
module ramp_adc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        man_rst_i;
  logic        cmp_i;
  logic        ramp_rst_o;
  logic [11:0] digits_o;
  logic        ovr_o;
  logic        done_o;

  always #5 clk = ~clk;

  ramp_adc_ctrl dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .man_rst_i (man_rst_i),
    .cmp_i     (cmp_i),
    .ramp_rst_o(ramp_rst_o),
    .digits_o  (digits_o),
    .ovr_o     (ovr_o),
    .done_o    (done_o)
  );

  // ramp model: held at zero while reset, rises one step per clock
  logic [11:0] vin;
  logic [11:0] ramp_q;
  always_ff @(posedge clk) begin
    if (ramp_rst_o)            ramp_q <= '0;
    else if (ramp_q != 12'hFFF) ramp_q <= ramp_q + 12'd1;
  end
  assign cmp_i = !ramp_rst_o && (ramp_q < vin);

  int  checks = 0;
  int  fails  = 0;
  bit  reported = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act='h%0h exp='h%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] to_bcd(input int v);
    int s;
    s = (v > 999) ? 999 : v;
    return {4'(s / 100), 4'((s / 10) % 10), 4'(s % 10)};
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // per-cycle monitor, samples away from the active edge
  int          cyc = 0;
  int          fall_cyc = -100;
  int          fall_cnt = 0;
  bit          prev_cmp = 0, prev_done = 0, prev2_done = 0, prev_man = 0;
  logic [11:0] last_digits = '0;
  bit          last_ovr = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++;
      if (prev_cmp && !cmp_i) begin
        fall_cyc = cyc;
        fall_cnt++;
      end
      if (done_o) begin
        chk(!prev_done, "R5", int'(prev_done), 0);
        chk(cyc == fall_cyc + 4, "R4", cyc - fall_cyc, 4);
        chk(ramp_rst_o, "R6", int'(ramp_rst_o), 1);
      end else begin
        chk(digits_o == last_digits && ovr_o == last_ovr, "R7",
            int'(digits_o), int'(last_digits));
      end
      if (prev_done) chk(ramp_rst_o, "R6", int'(ramp_rst_o), 1);
      if (prev2_done && !prev_done)
        chk(ramp_rst_o == man_rst_i, "R6", int'(ramp_rst_o), int'(man_rst_i));
      if (man_rst_i || prev_man) chk(ramp_rst_o, "R8", int'(ramp_rst_o), 1);
      prev_cmp    = cmp_i;
      prev2_done  = prev_done;
      prev_done   = done_o;
      prev_man    = man_rst_i;
      last_digits = digits_o;
      last_ovr    = ovr_o;
    end
  end

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #1;
      if (done_o) begin
        ok = 1'b1;
        break;
      end
    end
    if (!ok) chk(1'b0, "R5 timeout", 0, 1);
  endtask

  task automatic check_result(input int v, input string req);
    chk(digits_o == to_bcd(v), req, int'(digits_o), int'(to_bcd(v)));
    chk(ovr_o == (v > 999), req, int'(ovr_o), int'(v > 999));
  endtask

  initial begin
    int vals[$];
    bit ok;
    int fc;
    void'($urandom(32'd1234));
    vals = '{1, 9, 10, 99, 100, 998, 999, 1000, 1203};
    for (int i = 0; i < 8; i++) vals.push_back(1 + int'($urandom % 1100));

    rst_ni = 1'b0; man_rst_i = 1'b0; vin = 12'(vals[0]);
    repeat (3) @(negedge clk);
    chk(ramp_rst_o == 1'b1, "R1", int'(ramp_rst_o), 1);
    chk(digits_o == 12'h000 && ovr_o == 1'b0, "R1", int'(digits_o), 0);
    chk(done_o == 1'b0, "R1", int'(done_o), 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(ramp_rst_o == 1'b1, "R1", int'(ramp_rst_o), 1);

    // normal conversions, directed corners then random
    for (int i = 0; i < vals.size(); i++) begin
      wait_done(ok);
      if (!ok) report();
      check_result(vals[i], (vals[i] >= 999) ? "R3" : "R2");
      vin = (i + 1 < vals.size()) ? 12'(vals[i + 1]) : 12'd500;
    end

    // R8: manual reset mid-count discards the partial value
    repeat (100) @(posedge clk);
    #1 man_rst_i = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!done_o, "R8", int'(done_o), 0);
    end
    @(posedge clk); #1 man_rst_i = 1'b0;
    wait_done(ok);
    if (!ok) report();
    check_result(500, "R8");
    vin = 12'd37;

    // R9: manual reset in the capture cycle
    fc = fall_cnt;
    for (int n = 0; n < 3000 && fall_cnt == fc; n++) begin
      @(negedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1 man_rst_i = 1'b1;
    @(posedge clk); #1 man_rst_i = 1'b0;
    @(negedge clk); #1;
    chk(done_o == 1'b1, "R9", int'(done_o), 1);
    check_result(37, "R9");

    // R6: next conversion restarts from zero
    wait_done(ok);
    if (!ok) report();
    check_result(37, "R6");
    repeat (4) @(negedge clk);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end
endmodule